// File: doc/BRIEF.md
# Glitch-Free Multi-Output Chip-Select Controller

This block sits next to a synchronous serial port and owns its chip-select lines. The lines are active low. Software writes one control word. That word chooses between software and hardware control of the select. It carries a requested select state and picks one of several output lines through an index field. The block keeps the output index in a latched register and keeps the select state in a separate piece of control. The two are never changed on the same edge.

When the requested index differs from the latched one, the controller releases any active line first. It then loads the new index and holds every line inactive for a fixed number of serial clock cycles before it asserts the new line, so the old line cannot pulse. A deassert request, whether it comes from software or from the port's own frame request, waits until the serial engine reports idle. If the engine is still busy after a bounded number of cycles, the controller gives up, drops the select and sets a sticky timeout flag.

Top module: `cs_glitchfree_ctrl`

## Requirements
- R1: After reset all select outputs are high, `timeout_o` is 0, software control is on with the deasserted state, and the latched index is 0.
- R2: A control write sets software mode from bit 0 (1 = software) and the select state from bit 1 (0 = assert, 1 = deassert). It sets the index from the field of width `IDX_W` that starts at bit `IDX_LSB` (bits 9:8 by default; a 1-bit field at bit 2 suits two outputs).
- R3: With bit 0 clear, the selected line follows `hw_req_i`. It goes low one cycle after `hw_req_i` is sampled high and is released through the busy wait of R7.
- R4: At most one output is low at any time, and every output other than the latched index is high.
- R5: A new index is loaded only while all outputs are high. After the load, all outputs stay high for `SWITCH_WAIT` (2) cycles, and only then is the new line asserted.
- R6: A write whose index equals the latched index causes no wait: an assert request drives that line low one cycle after the write.
- R7: A deassert request takes effect only once `busy_i` is low. The line goes high the cycle after the drain begins if the engine is idle, and otherwise one cycle after `busy_i` falls.
- R8: If `busy_i` stays high for `TIMEOUT` cycles of draining, the line is released anyway and `timeout_o` is set. It stays set until reset.
- R9: A written index of `NUM_CS` or above is ignored: the latched and pending selection remain unchanged.
- R10: An index change requested while a line is asserted first drains and releases the old line (R7), then performs the switch and wait of R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock domain clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | CTRL_W | Control word |
| hw_req_i | input | 1 | Select request from the serial engine (used in hardware mode) |
| busy_i | input | 1 | Serial engine busy flag |
| cs_no_o | output | NUM_CS | Chip-select lines, active low |
| timeout_o | output | 1 | Sticky flag: a drain timed out |

## Verification
Directed patterns cover four cases. A same-index assert is told apart from an index change by the presence of the two-cycle all-high gap. A deassert with the engine idle is told apart from one with busy held, and from one with busy stuck until the timeout. An index change issued while a line is active shows that the old line drains before the switch. An out-of-range index shows that the current line is kept. Random mixes of software and hardware mode, state and index, each followed by a settle window, check the steady select pattern against a bench model of the latched index.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic [1:0] {
    CS_IDLE   = 2'd0,
    CS_SWITCH = 2'd1,
    CS_ACTIVE = 2'd2,
    CS_DRAIN  = 2'd3
  } cs_state_e;

  localparam int unsigned SW_MODE_BIT = 0;
  localparam int unsigned STATE_BIT   = 1;
endpackage

// File: rtl/cs_ctrl_regs.sv
module cs_ctrl_regs #(
  parameter int unsigned CTRL_W  = 32,
  parameter int unsigned IDX_LSB = 8,
  parameter int unsigned IDX_W   = 2,
  parameter int unsigned NUM_CS  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic              sw_mode_o,
  output logic              sw_state_o,
  output logic [IDX_W-1:0]  pend_idx_o
);
  import cs_pkg::*;

  localparam int unsigned FULL_RANGE = (NUM_CS == (1 << IDX_W)) ? 1 : 0;

  logic [IDX_W-1:0] wr_idx;
  logic             idx_ok;

  assign wr_idx = wdata_i[IDX_LSB +: IDX_W];

  generate
    if (FULL_RANGE == 1) begin : g_full
      assign idx_ok = 1'b1;
    end else begin : g_part
      assign idx_ok = ({1'b0, wr_idx} < (IDX_W + 1)'(NUM_CS));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_mode_o  <= 1'b1;
      sw_state_o <= 1'b1;
      pend_idx_o <= '0;
    end else if (we_i) begin
      sw_mode_o  <= wdata_i[SW_MODE_BIT];
      sw_state_o <= wdata_i[STATE_BIT];
      if (idx_ok) pend_idx_o <= wr_idx;
    end
  end
endmodule

// File: rtl/cs_seq_fsm.sv
module cs_seq_fsm #(
  parameter int unsigned IDX_W       = 2,
  parameter int unsigned SWITCH_WAIT = 2,
  parameter int unsigned TIMEOUT     = 1250000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              busy_i,
  input  logic [IDX_W-1:0]  pend_idx_i,
  output logic [IDX_W-1:0]  idx_d_o,
  output logic              active_d_o,
  output logic              timeout_o
);
  import cs_pkg::*;

  localparam int unsigned WAIT_W = $clog2(SWITCH_WAIT + 1);
  localparam int unsigned TMO_W  = $clog2(TIMEOUT + 1);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(SWITCH_WAIT - 1);
  localparam logic [TMO_W-1:0]  TMO_LAST  = TMO_W'(TIMEOUT - 1);

  cs_state_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [WAIT_W-1:0] wcnt_q, wcnt_d;
  logic [TMO_W-1:0]  tcnt_q, tcnt_d;
  logic              tmo_q, tmo_d;
  logic              idx_diff;

  assign idx_diff = (pend_idx_i != idx_q);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    wcnt_d  = wcnt_q;
    tcnt_d  = tcnt_q;
    tmo_d   = tmo_q;
    unique case (state_q)
      CS_IDLE: begin
        if (idx_diff) begin
          // mux moves while every line is high
          idx_d   = pend_idx_i;
          wcnt_d  = '0;
          state_d = CS_SWITCH;
        end else if (req_i) begin
          state_d = CS_ACTIVE;
        end
      end
      CS_SWITCH: begin
        if (wcnt_q == WAIT_LAST) begin
          state_d = (!idx_diff && req_i) ? CS_ACTIVE : CS_IDLE;
        end else begin
          wcnt_d = wcnt_q + 1'b1;
        end
      end
      CS_ACTIVE: begin
        if (!req_i || idx_diff) begin
          tcnt_d  = '0;
          state_d = CS_DRAIN;
        end
      end
      CS_DRAIN: begin
        if (!busy_i) begin
          state_d = CS_IDLE;
        end else if (tcnt_q == TMO_LAST) begin
          tmo_d   = 1'b1;
          state_d = CS_IDLE;
        end else begin
          tcnt_d = tcnt_q + 1'b1;
        end
      end
      default: state_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CS_IDLE;
      idx_q   <= '0;
      wcnt_q  <= '0;
      tcnt_q  <= '0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      wcnt_q  <= wcnt_d;
      tcnt_q  <= tcnt_d;
      tmo_q   <= tmo_d;
    end
  end

  assign idx_d_o    = idx_d;
  assign active_d_o = (state_d == CS_ACTIVE) || (state_d == CS_DRAIN);
  assign timeout_o  = tmo_q;
endmodule

// File: rtl/cs_out_dec.sv
module cs_out_dec #(
  parameter int unsigned NUM_CS = 4,
  parameter int unsigned IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              active_i,
  output logic [NUM_CS-1:0] cs_no
);
  // registered decode: each line has its own flop, no decode glitches
  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cs_no[i] <= 1'b1;
      else         cs_no[i] <= !(active_i && (idx_i == IDX_W'(i)));
    end
  end
endmodule

// File: rtl/cs_glitchfree_ctrl.sv
module cs_glitchfree_ctrl #(
  parameter int unsigned CTRL_W      = 32,
  parameter int unsigned NUM_CS      = 4,
  parameter int unsigned IDX_LSB     = 8,
  parameter int unsigned IDX_W       = 2,
  parameter int unsigned SWITCH_WAIT = 2,
  parameter int unsigned TIMEOUT     = 1250000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              hw_req_i,
  input  logic              busy_i,
  output logic [NUM_CS-1:0] cs_no_o,
  output logic              timeout_o
);
  logic             sw_mode, sw_state, req;
  logic [IDX_W-1:0] pend_idx, idx_d;
  logic             active_d;

  cs_ctrl_regs #(
    .CTRL_W (CTRL_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W), .NUM_CS(NUM_CS)
  ) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (ctrl_we_i),
    .wdata_i   (ctrl_wdata_i),
    .sw_mode_o (sw_mode),
    .sw_state_o(sw_state),
    .pend_idx_o(pend_idx)
  );

  // state bit 1 means released
  assign req = sw_mode ? !sw_state : hw_req_i;

  cs_seq_fsm #(
    .IDX_W(IDX_W), .SWITCH_WAIT(SWITCH_WAIT), .TIMEOUT(TIMEOUT)
  ) i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req),
    .busy_i    (busy_i),
    .pend_idx_i(pend_idx),
    .idx_d_o   (idx_d),
    .active_d_o(active_d),
    .timeout_o (timeout_o)
  );

  cs_out_dec #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) i_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .idx_i   (idx_d),
    .active_i(active_d),
    .cs_no   (cs_no_o)
  );
endmodule

// File: rtl/cs_glitchfree_chk.sv
module cs_glitchfree_chk #(
  parameter int unsigned NUM_CS      = 4,
  parameter int unsigned SWITCH_WAIT = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic [NUM_CS-1:0] cs_no_o,
  input logic              timeout_o
);
  localparam logic [NUM_CS-1:0] ALL_HI = '1;

  logic [NUM_CS-1:0] act, last_q;
  logic [7:0]        idle_q;
  logic              all_hi;

  assign act    = ~cs_no_o;
  assign all_hi = (cs_no_o == ALL_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      idle_q <= '0;
    end else begin
      if (!all_hi) last_q <= act;
      if (all_hi) idle_q <= (idle_q == 8'hff) ? idle_q : idle_q + 8'd1;
      else        idle_q <= '0;
    end
  end

  // R4
  one_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act));

  // R4
  no_hop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !all_hi |=> (all_hi || cs_no_o == $past(cs_no_o)));

  // R5
  switch_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!all_hi && last_q != '0 && act != last_q) |-> (idle_q >= 8'(SWITCH_WAIT)));

  // R7
  hold_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!all_hi && busy_i) |=> (cs_no_o == $past(cs_no_o) || timeout_o));

  // R8
  sticky_tmo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> timeout_o);
endmodule

bind cs_glitchfree_ctrl cs_glitchfree_chk #(
  .NUM_CS(NUM_CS), .SWITCH_WAIT(SWITCH_WAIT)
) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_i   (busy_i),
  .cs_no_o  (cs_no_o),
  .timeout_o(timeout_o)
);

// File: tb/test_cs_glitchfree_ctrl.sv
module test_cs_glitchfree_ctrl;
  localparam int N   = 3;
  localparam int IW  = 2;
  localparam int IL  = 8;
  localparam int TMO = 40;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ctrl_we_i = 1'b0;
  logic [31:0]   ctrl_wdata_i = '0;
  logic          hw_req_i = 1'b0;
  logic          busy_i = 1'b0;
  logic [N-1:0]  cs_no_o;
  logic          timeout_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  cs_glitchfree_ctrl #(
    .CTRL_W(32), .NUM_CS(N), .IDX_LSB(IL), .IDX_W(IW),
    .SWITCH_WAIT(2), .TIMEOUT(TMO)
  ) i_cs_glitchfree_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_we_i(ctrl_we_i),
    .ctrl_wdata_i(ctrl_wdata_i), .hw_req_i(hw_req_i), .busy_i(busy_i),
    .cs_no_o(cs_no_o), .timeout_o(timeout_o)
  );

  function automatic logic [N-1:0] exp_cs(int idx, bit on);
    logic [N-1:0] v = '1;
    if (on) v[idx] = 1'b0;
    return v;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic wr(bit sw, bit st, int idx);
    @(negedge clk_i);
    ctrl_we_i    = 1'b1;
    ctrl_wdata_i = (32'(idx) << IL) | (32'(st) << 1) | 32'(sw);
    @(negedge clk_i);
    ctrl_we_i = 1'b0;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    int eidx;
    void'($urandom(32'd4242));
    step(3);
    // R1
    chk("R1 cs", 8'(cs_no_o), 8'(exp_cs(0, 0)));
    chk("R1 tmo", 8'(timeout_o), 8'd0);
    rst_ni = 1'b1;
    step(2);
    chk("R1 idle", 8'(cs_no_o), 8'(exp_cs(0, 0)));

    // R6 R2: same index, assert next cycle
    wr(1, 0, 0);
    step(1);
    chk("R6 assert", 8'(cs_no_o), 8'(exp_cs(0, 1)));

    // R7: deassert with idle engine
    wr(1, 1, 0);
    step(1);
    chk("R7 drain", 8'(cs_no_o), 8'(exp_cs(0, 1)));
    step(1);
    chk("R7 release", 8'(cs_no_o), 8'(exp_cs(0, 0)));

    // R5: index change, two-cycle gap
    wr(1, 0, 2);
    step(1);
    chk("R5 gap1", 8'(cs_no_o), 8'(exp_cs(0, 0)));
    step(1);
    chk("R5 gap2", 8'(cs_no_o), 8'(exp_cs(0, 0)));
    step(1);
    chk("R5 assert", 8'(cs_no_o), 8'(exp_cs(2, 1)));

    // R7: busy held
    busy_i = 1'b1;
    wr(1, 1, 2);
    for (int k = 0; k < 10; k++) begin
      step(1);
      chk("R7 hold", 8'(cs_no_o), 8'(exp_cs(2, 1)));
    end
    busy_i = 1'b0;
    step(1);
    chk("R7 busy fall", 8'(cs_no_o), 8'(exp_cs(2, 0)));
    chk("R7 no tmo", 8'(timeout_o), 8'd0);

    // R8: busy stuck
    wr(1, 0, 2);
    step(1);
    chk("R8 pre", 8'(cs_no_o), 8'(exp_cs(2, 1)));
    busy_i = 1'b1;
    wr(1, 1, 2);
    step(TMO);
    chk("R8 last held", 8'(cs_no_o), 8'(exp_cs(2, 1)));
    chk("R8 tmo clear", 8'(timeout_o), 8'd0);
    step(1);
    chk("R8 released", 8'(cs_no_o), 8'(exp_cs(2, 0)));
    chk("R8 tmo set", 8'(timeout_o), 8'd1);
    busy_i = 1'b0;
    step(2);

    // R9: index 3 out of range
    wr(1, 0, 3);
    step(1);
    chk("R9 kept", 8'(cs_no_o), 8'(exp_cs(2, 1)));
    step(3);
    chk("R9 steady", 8'(cs_no_o), 8'(exp_cs(2, 1)));

    // R10: change while active
    busy_i = 1'b1;
    wr(1, 0, 1);
    for (int k = 0; k < 5; k++) begin
      step(1);
      chk("R10 old held", 8'(cs_no_o), 8'(exp_cs(2, 1)));
    end
    busy_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      step(1);
      chk("R10 gap", 8'(cs_no_o), 8'(exp_cs(0, 0)));
    end
    step(1);
    chk("R10 new", 8'(cs_no_o), 8'(exp_cs(1, 1)));

    // R3: hardware mode
    wr(0, 1, 1);
    step(2);
    chk("R3 off", 8'(cs_no_o), 8'(exp_cs(1, 0)));
    hw_req_i = 1'b1;
    step(1);
    chk("R3 on", 8'(cs_no_o), 8'(exp_cs(1, 1)));
    hw_req_i = 1'b0;
    step(2);
    chk("R3 off2", 8'(cs_no_o), 8'(exp_cs(1, 0)));

    // R2 R4 R9: random mix
    eidx = 1;
    for (int it = 0; it < 60; it++) begin
      bit sw = ($urandom % 4) != 0;
      bit st = $urandom % 2;
      bit hw = $urandom % 2;
      int ix = $urandom % 4;
      bit on;
      @(negedge clk_i);
      hw_req_i = hw;
      wr(sw, st, ix);
      if (ix < N) eidx = ix;
      on = sw ? !st : hw;
      step(8);
      chk("R2 random", 8'(cs_no_o), 8'(exp_cs(eidx, on)));
    end
    chk("R8 sticky end", 8'(timeout_o), 8'd1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule